// File: doc/BRIEF.md
# Multi-channel match-compare timer

This peripheral holds three independent 32-bit up-counters. Each counter advances on the cycles in which a tick-enable line that it selects is high. Each counter has three comparators. A comparator sets a sticky status bit when the count reaches its stored value. Each timer drives one interrupt line, raised while any of its status bits is set and enabled.

Software reaches the block over a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. Software uses it to start and stop the counters and to choose between periodic and free-running counting. It also sets the comparator values, the preload value, the interrupt mask and the tick source, and it clears status bits.

Software reads the count through a snapshot register. It first writes the register to capture the count, then reads the register back. The register address map is kept fixed, because drivers address it by fixed offsets.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads 0, the counters hold 0, and all interrupt outputs are low.
- R2: The byte addresses for timer n (0..2) and comparator m (0..2) are as follows. Each reads back the last value written to it: tick select 0x00 (7 bits), comparator value 0x04+12n+4m, preload value 0x4C+4n, preload control 0x58+4n (bit 0), interrupt mask 0x40+4n (bit m), run control 0x84 (bit n), count mode 0x88 (bit n). Other reads: live count 0x28+4n, status 0x34+4n (bit m), snapshot 0xA4+4n.
- R3: While bit n of the run-control register is 0, counter n keeps its value, whatever its tick line does.
- R4: Writing 1 to bit n of run control while that bit is 0 loads counter n from its preload value on that edge.
- R5: In the tick-select register, timer 0 takes its field from bits [1:0], timer 1 from bits [4:2] and timer 2 from bits [6:5]. The field value k picks tick_src[k]. A running counter adds one on each cycle its selected tick line is high, and it wraps from all-ones to 0.
- R6: On a counting cycle where the count equals comparator m's value, status bit m of that timer is set. So a value of D-1 sets the status bit on the D-th tick after a load of 0.
- R7: When count-mode bit n is 0 and preload-control bit 0 of timer n is 1, a comparator-0 match reloads the counter from the preload value instead of incrementing it. In every other combination the counter runs freely.
- R8: Writing to 0x74+4n clears the status bits of timer n at the positions written with 1, and leaves the other positions as they are. A match in the same cycle wins over the clear. Status bits stay set until they are cleared.
- R9: irq[n] is high exactly when some status bit of timer n is set and its interrupt-mask bit is 1.
- R10: A write to 0xA4+4n captures, on the second clock edge after the write edge, the count that counter n held just before that edge. Later reads of the address return the captured value.
- R11: Writes to the live count, to the status registers and to unmapped addresses have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_src | input | 8 | Tick-enable lines that the timers select from |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | One interrupt line per timer |

## Verification
A wrong count shows up on the live-count read in the same cycle. It also moves the cycle in which a status bit rises, so the interrupt line of an enabled comparator goes high a cycle early or late. A wrong periodic reload shifts every later match of that timer, so the error grows period by period. A lost or late snapshot shows on the snapshot read two edges after the request, and a status bit that is stuck or cleared wrongly shows at once on irq whenever its mask bit is set.

// File: rtl/mct_pkg.sv
package mct_pkg;
   localparam int SRC_SEL_W  = 3;
   localparam int SRC_N      = 1 << SRC_SEL_W;
   localparam int CLK_CTRL_W = 7;

   localparam logic [7:0] OFS_CLK   = 8'h00;
   localparam logic [7:0] OFS_CNT   = 8'h28;
   localparam logic [7:0] OFS_STAT  = 8'h34;
   localparam logic [7:0] OFS_IEN   = 8'h40;
   localparam logic [7:0] OFS_PRE   = 8'h4C;
   localparam logic [7:0] OFS_PCTL  = 8'h58;
   localparam logic [7:0] OFS_ICLR  = 8'h74;
   localparam logic [7:0] OFS_RUN   = 8'h84;
   localparam logic [7:0] OFS_MODE  = 8'h88;
   localparam logic [7:0] OFS_SNAP  = 8'hA4;

   // comparator registers interleave by timer and comparator index
   function automatic logic [7:0] match_ofs(int n, int m);
      return 8'(4 + 8 * n + 4 * (n + m));
   endfunction

   function automatic logic [7:0] tmr_ofs(logic [7:0] base, int n);
      return 8'(int'(base) + 4 * n);
   endfunction

   function automatic int csel_lo(int n);
      return (n == 0) ? 0 : ((n == 1) ? 2 : 5);
   endfunction

   function automatic int csel_w(int n);
      return (n == 1) ? 3 : 2;
   endfunction
endpackage

// File: rtl/mct_channel.sv
module mct_channel #(
   parameter int CW = 32,
   parameter int NC = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  run,
   input  logic                  start,
   input  logic                  periodic,
   input  logic [CW-1:0]         preload,
   input  logic [NC-1:0][CW-1:0] match_val,
   input  logic [NC-1:0]         clr,
   input  logic [NC-1:0]         ien,
   output logic [CW-1:0]         count,
   output logic [NC-1:0]         status,
   output logic                  irq
);
   logic          step;
   logic [NC-1:0] hit;

   assign step = run && tick;

   for (genvar m = 0; m < NC; m++) begin : g_cmp
      assign hit[m] = step && (count == match_val[m]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         status <= '0;
      end else begin
         if (start)
            count <= preload;
         else if (step)
            count <= (periodic && hit[0]) ? preload : count + 1'b1;
         status <= (status & ~clr) | hit;
      end
   end

   assign irq = |(status & ien);
endmodule

// File: rtl/mct_snap.sv
module mct_snap #(
   parameter int CW  = 32,
   parameter int DLY = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [CW-1:0] live,
   output logic [CW-1:0] snap
);
   logic [DLY-1:0] pipe;

   if (DLY < 1) begin : g_bad_dly
      $error("mct_snap: DLY must be at least 1");
   end

   if (DLY == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) pipe <= '0;
         else        pipe <= req;
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) pipe <= '0;
         else        pipe <= {pipe[DLY-2:0], req};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             snap <= '0;
      else if (pipe[DLY-1])   snap <= live;
   end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
   import mct_pkg::*;
#(
   parameter int N_TMR    = 3,
   parameter int N_CMP    = 3,
   parameter int CW       = 32,
   parameter int AW       = 8,
   parameter int DW       = 32,
   parameter int SNAP_DLY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] tick_src,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_we,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   output logic [N_TMR-1:0] irq
);
   if (N_TMR != 3 || N_CMP != 3) begin : g_bad_count
      $error("mct_timer: the address map fixes three timers of three comparators");
   end
   if (DW < CW || AW != 8) begin : g_bad_width
      $error("mct_timer: data must hold a count and addresses are 8 bits");
   end

   logic [CLK_CTRL_W-1:0]                clk_ctrl_q;
   logic [N_TMR-1:0]                     run_q, mode_q, pctl_q;
   logic [N_TMR-1:0][CW-1:0]             pre_q, cnt, snap;
   logic [N_TMR-1:0][N_CMP-1:0][CW-1:0]  match_q;
   logic [N_TMR-1:0][N_CMP-1:0]          ien_q, status, clr;
   logic [N_TMR-1:0]                     tick, start, periodic, snap_req;
   logic                                 wr_run;

   assign wr_run = bus_we && (bus_addr == AW'(OFS_RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_ctrl_q <= '0;
         run_q      <= '0;
         mode_q     <= '0;
         pctl_q     <= '0;
         pre_q      <= '0;
         match_q    <= '0;
         ien_q      <= '0;
      end else begin
         if (bus_we && bus_addr == AW'(OFS_CLK))  clk_ctrl_q <= bus_wdata[CLK_CTRL_W-1:0];
         if (wr_run)                              run_q      <= bus_wdata[N_TMR-1:0];
         if (bus_we && bus_addr == AW'(OFS_MODE)) mode_q     <= bus_wdata[N_TMR-1:0];
         for (int n = 0; n < N_TMR; n++) begin
            if (bus_we && bus_addr == AW'(tmr_ofs(OFS_PRE, n)))  pre_q[n]  <= bus_wdata[CW-1:0];
            if (bus_we && bus_addr == AW'(tmr_ofs(OFS_PCTL, n))) pctl_q[n] <= bus_wdata[0];
            if (bus_we && bus_addr == AW'(tmr_ofs(OFS_IEN, n)))  ien_q[n]  <= bus_wdata[N_CMP-1:0];
            for (int m = 0; m < N_CMP; m++)
               if (bus_we && bus_addr == AW'(match_ofs(n, m))) match_q[n][m] <= bus_wdata[CW-1:0];
         end
      end
   end

   for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
      localparam int LO = csel_lo(n);
      localparam int W  = csel_w(n);
      logic [SRC_SEL_W-1:0] sel;

      assign sel         = SRC_SEL_W'(clk_ctrl_q[LO +: W]);
      assign tick[n]     = tick_src[sel];
      assign start[n]    = wr_run && bus_wdata[n] && !run_q[n];
      assign periodic[n] = !mode_q[n] && pctl_q[n];
      assign snap_req[n] = bus_we && (bus_addr == AW'(tmr_ofs(OFS_SNAP, n)));
      assign clr[n]      = (bus_we && bus_addr == AW'(tmr_ofs(OFS_ICLR, n))) ?
                           bus_wdata[N_CMP-1:0] : '0;

      mct_channel #(.CW(CW), .NC(N_CMP)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick[n]),
         .run       (run_q[n]),
         .start     (start[n]),
         .periodic  (periodic[n]),
         .preload   (pre_q[n]),
         .match_val (match_q[n]),
         .clr       (clr[n]),
         .ien       (ien_q[n]),
         .count     (cnt[n]),
         .status    (status[n]),
         .irq       (irq[n])
      );

      mct_snap #(.CW(CW), .DLY(SNAP_DLY)) u_snap (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (snap_req[n]),
         .live  (cnt[n]),
         .snap  (snap[n])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(OFS_CLK))  bus_rdata = DW'(clk_ctrl_q);
      if (bus_addr == AW'(OFS_RUN))  bus_rdata = DW'(run_q);
      if (bus_addr == AW'(OFS_MODE)) bus_rdata = DW'(mode_q);
      for (int n = 0; n < N_TMR; n++) begin
         if (bus_addr == AW'(tmr_ofs(OFS_CNT, n)))  bus_rdata = DW'(cnt[n]);
         if (bus_addr == AW'(tmr_ofs(OFS_STAT, n))) bus_rdata = DW'(status[n]);
         if (bus_addr == AW'(tmr_ofs(OFS_IEN, n)))  bus_rdata = DW'(ien_q[n]);
         if (bus_addr == AW'(tmr_ofs(OFS_PRE, n)))  bus_rdata = DW'(pre_q[n]);
         if (bus_addr == AW'(tmr_ofs(OFS_PCTL, n))) bus_rdata = DW'(pctl_q[n]);
         if (bus_addr == AW'(tmr_ofs(OFS_SNAP, n))) bus_rdata = DW'(snap[n]);
         for (int m = 0; m < N_CMP; m++)
            if (bus_addr == AW'(match_ofs(n, m))) bus_rdata = DW'(match_q[n][m]);
      end
   end
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
   parameter int N_TMR = 3,
   parameter int N_CMP = 3,
   parameter int CW    = 32
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic [N_TMR-1:0]                    run_q,
   input logic [N_TMR-1:0]                    start,
   input logic [N_TMR-1:0]                    tick,
   input logic [N_TMR-1:0]                    periodic,
   input logic [N_TMR-1:0][CW-1:0]            cnt,
   input logic [N_TMR-1:0][CW-1:0]            pre_q,
   input logic [N_TMR-1:0][N_CMP-1:0][CW-1:0] match_q,
   input logic [N_TMR-1:0][N_CMP-1:0]         status,
   input logic [N_TMR-1:0][N_CMP-1:0]         clr,
   input logic [N_TMR-1:0][N_CMP-1:0]         ien_q,
   input logic [N_TMR-1:0]                    irq
);
   for (genvar n = 0; n < N_TMR; n++) begin : g_t
      AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
         !run_q[n] && !start[n] |=> cnt[n] == $past(cnt[n])); // R3

      AST_LOAD_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         start[n] |=> cnt[n] == $past(pre_q[n])); // R4

      AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         run_q[n] && tick[n] && periodic[n] && cnt[n] == match_q[n][0]
         |=> cnt[n] == $past(pre_q[n])); // R7

      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         ien_q[n] == '0 |-> !irq[n]); // R9

      for (genvar m = 0; m < N_CMP; m++) begin : g_c
         AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            run_q[n] && tick[n] && cnt[n] == match_q[n][m] |=> status[n][m]); // R6

         AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            status[n][m] && !clr[n][m] |=> status[n][m]); // R8
      end
   end
endmodule

bind mct_timer mct_timer_chk #(.N_TMR(N_TMR), .N_CMP(N_CMP), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_q    (run_q),
   .start    (start),
   .tick     (tick),
   .periodic (periodic),
   .cnt      (cnt),
   .pre_q    (pre_q),
   .match_q  (match_q),
   .status   (status),
   .clr      (clr),
   .ien_q    (ien_q),
   .irq      (irq)
);

// File: tb/sim_mct_timer.sv
module sim_mct_timer;
   localparam int TCK = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  tick_src = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(TCK/2) clk = ~clk;

   mct_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference model
   logic [31:0] m_cnt [3], m_pre [3], m_snap [3], t_cnt [3];
   logic [31:0] m_mt [3][3];
   logic [2:0]  m_st [3], m_ie [3], t_st [3];
   logic        m_plc [3];
   logic [2:0]  m_en, m_mode, h, c;
   logic [6:0]  m_cc;
   int          cyc;
   int          mq[$];

   function automatic int msel(int n);
      case (n)
         0:       return int'(m_cc[1:0]);
         1:       return int'(m_cc[4:2]);
         default: return int'(m_cc[6:5]);
      endcase
   endfunction

   function automatic logic [31:0] mrd(logic [7:0] a);
      logic [31:0] r = '0;
      if (a == 8'h00) r = {25'd0, m_cc};
      if (a == 8'h84) r = {29'd0, m_en};
      if (a == 8'h88) r = {29'd0, m_mode};
      for (int n = 0; n < 3; n++) begin
         if (a == 8'(8'h28 + 4*n)) r = m_cnt[n];
         if (a == 8'(8'h34 + 4*n)) r = {29'd0, m_st[n]};
         if (a == 8'(8'h40 + 4*n)) r = {29'd0, m_ie[n]};
         if (a == 8'(8'h4C + 4*n)) r = m_pre[n];
         if (a == 8'(8'h58 + 4*n)) r = {31'd0, m_plc[n]};
         if (a == 8'(8'hA4 + 4*n)) r = m_snap[n];
         for (int m = 0; m < 3; m++)
            if (a == 8'(4 + 12*n + 4*m)) r = m_mt[n][m];
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < 3; n++) begin
            m_cnt[n] = '0; m_pre[n] = '0; m_snap[n] = '0;
            m_st[n] = '0; m_ie[n] = '0; m_plc[n] = 1'b0;
            for (int m = 0; m < 3; m++) m_mt[n][m] = '0;
         end
         m_en = '0; m_mode = '0; m_cc = '0; cyc = 0;
         mq.delete();
      end else begin
         cyc++;
         for (int i = mq.size() - 1; i >= 0; i--)
            if (mq[i] / 4 == cyc) begin
               m_snap[mq[i] % 4] = m_cnt[mq[i] % 4];
               mq.delete(i);
            end
         for (int n = 0; n < 3; n++) begin
            bit tk, st;
            tk = m_en[n] && tick_src[msel(n)];
            h = '0;
            for (int m = 0; m < 3; m++) if (tk && m_cnt[n] == m_mt[n][m]) h[m] = 1'b1;
            c = (bus_we && bus_addr == 8'(8'h74 + 4*n)) ? bus_wdata[2:0] : 3'b000;
            t_st[n] = (m_st[n] & ~c) | h;
            st = bus_we && bus_addr == 8'h84 && bus_wdata[n] && !m_en[n];
            if (st) t_cnt[n] = m_pre[n];
            else if (tk && !m_mode[n] && m_plc[n] && h[0]) t_cnt[n] = m_pre[n];
            else if (tk) t_cnt[n] = m_cnt[n] + 32'd1;
            else t_cnt[n] = m_cnt[n];
         end
         for (int n = 0; n < 3; n++) begin
            m_cnt[n] = t_cnt[n];
            m_st[n] = t_st[n];
         end
         if (bus_we) begin
            if (bus_addr == 8'h00) m_cc = bus_wdata[6:0];
            if (bus_addr == 8'h84) m_en = bus_wdata[2:0];
            if (bus_addr == 8'h88) m_mode = bus_wdata[2:0];
            for (int n = 0; n < 3; n++) begin
               if (bus_addr == 8'(8'h4C + 4*n)) m_pre[n] = bus_wdata;
               if (bus_addr == 8'(8'h58 + 4*n)) m_plc[n] = bus_wdata[0];
               if (bus_addr == 8'(8'h40 + 4*n)) m_ie[n] = bus_wdata[2:0];
               if (bus_addr == 8'(8'hA4 + 4*n)) mq.push_back((cyc + 2) * 4 + n);
               for (int m = 0; m < 3; m++)
                  if (bus_addr == 8'(4 + 12*n + 4*m)) m_mt[n][m] = bus_wdata;
            end
         end
      end
   end

   // compare model and design every clock
   always @(posedge clk) begin
      #(TCK/4);
      if (rst_n && !done) begin
         logic [2:0] ei;
         for (int n = 0; n < 3; n++) ei[n] = |(m_st[n] & m_ie[n]);
         checks++;
         if (bus_rdata !== mrd(bus_addr)) begin
            errors++;
            $display("FAIL R2 read addr %h got %h exp %h", bus_addr, bus_rdata, mrd(bus_addr));
         end
         checks++;
         if (irq !== ei) begin
            errors++;
            $display("FAIL R9 irq got %b exp %b", irq, ei);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", {29'd0, irq}, 32'd0);
      rd("R1 run", 8'h84, 0);
      rd("R1 status", 8'h34, 0);
      rd("R1 match", 8'h04, 0);

      // R6 R7 R9: timer 0 periodic, match values 4, 2, 0xFFFF
      wr(8'h04, 4); wr(8'h08, 2); wr(8'h0C, 32'hFFFF);
      wr(8'h40, 3'b010); wr(8'h58, 1); wr(8'h84, 1);
      tick_src = 8'h01; bus_addr = 8'h34;
      repeat (2) @(negedge clk);
      rd("R6 status before", 8'h34, 0);
      @(negedge clk);
      rd("R6 status at third tick", 8'h34, 3'b010);
      chk("R9 irq0 raised", {31'd0, irq[0]}, 1);
      repeat (2) @(negedge clk);
      rd("R7 status after reload", 8'h34, 3'b011);
      rd("R7 reloaded count", 8'h28, 0);
      tick_src = 8'h00;

      // R8 write-one-to-clear
      wr(8'h74, 1);
      rd("R8 partial clear", 8'h34, 3'b010);
      wr(8'h74, 2);
      rd("R8 full clear", 8'h34, 0);
      chk("R9 irq0 dropped", {31'd0, irq[0]}, 0);

      // R3 stopped counter holds
      wr(8'h84, 0);
      tick_src = 8'hFF;
      repeat (4) @(negedge clk);
      rd("R3 hold", 8'h28, 0);
      tick_src = 8'h00;

      // R4 enable loads preload
      wr(8'h4C, 100); wr(8'h84, 1);
      rd("R4 load", 8'h28, 100);

      // R5 timer 1 on tick_src[3], wraps
      wr(8'h00, 8'h0C); wr(8'h50, 32'hFFFF_FFFE); wr(8'h88, 2); wr(8'h84, 3);
      tick_src = 8'h08;
      repeat (3) @(negedge clk);
      rd("R5 wrap", 8'h2C, 1);
      rd("R5 other timer idle", 8'h28, 100);

      // R10 snapshot two edges later
      wr(8'hA8, 0);
      rd("R10 not yet", 8'hA8, 0);
      @(negedge clk);
      rd("R10 not yet 2", 8'hA8, 0);
      @(negedge clk);
      rd("R10 captured", 8'hA8, 3);
      tick_src = 8'h00;

      // R11 ignored writes
      wr(8'h30, 55);
      rd("R11 count write", 8'h30, 0);
      wr(8'h3C, 7);
      rd("R11 status write", 8'h3C, 0);
      wr(8'hF0, 32'hDEAD);
      rd("R11 unmapped", 8'hF0, 0);

      // R5 R6 R9 timer 2 on tick_src[2], masked bits
      wr(8'h00, 8'h4C); wr(8'h48, 4); wr(8'h24, 1); wr(8'h84, 7);
      tick_src = 8'h04;
      @(negedge clk);
      rd("R6 t2 status", 8'h3C, 3'b011);
      chk("R9 t2 masked", {31'd0, irq[2]}, 0);
      @(negedge clk);
      rd("R6 t2 status 2", 8'h3C, 3'b111);
      chk("R9 t2 raised", {31'd0, irq[2]}, 1);

      // mixed traffic against the model (R2 R9 per clock)
      for (int i = 0; i < 3000; i++) begin
         tick_src = 8'($urandom);
         bus_we = ($urandom % 3) == 0;
         bus_addr = 8'($urandom % 176) & 8'hFC;
         bus_wdata = (($urandom % 4) == 0) ? $urandom : ($urandom % 24);
         @(negedge clk);
      end
      bus_we = 1'b0;
      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(TCK * 20000);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog got running exp finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule